// File: doc/BRIEF.md
# Configuration Register Loader Driven by a Write Map

This block programs a set of hardware configuration registers before the software side of a function begins. A write map in a descriptor memory holds an ordered list of write descriptors. Each descriptor names a target register address, a 16-bit source index and a 16-bit word offset. For each descriptor the block resolves the source index into a 32-bit value. It then issues one memory-mapped write and waits for that write to be accepted before it moves to the next descriptor.

A source index can name one of four things: a decoded caller parameter, an entry in a pool of constants, an immediate scalar carried in the offset field, or a reference by name that writes a parameter's number instead of its value. Parameters and constants share a tagged format in which a 4-bit byte count gives their length. A multi-word entry is read at the given 32-bit word offset. When the whole list has been written, or an error has stopped it, the block pulses done for one cycle. Software is released on that pulse.

Top module: `cml_loader`

## Requirements
- R1: After reset, done, err, wr_valid, desc_rd_en and val_rd_en are all low.
- R2: On start with a count N from 1 to 64, descriptors 0 to N-1 are read in ascending order and exactly N writes are issued in that order. Each write uses the address field of its descriptor. A descriptor is 64 bits: address in [63:32], index in [31:16], offset in [15:0].
- R3: An index below 64 selects caller parameter number index. It is valid only when index is below par_count, and the written data is 32-bit word number offset of that parameter.
- R4: An index from 64 to 0xFFFD selects constant number index-64. It is valid only when that number is below const_count, and the written data is word number offset of that constant.
- R5: Index 0xFFFE writes the offset field, zero-extended to 32 bits, and never causes an error.
- R6: Index 0xFFFF writes the offset field, zero-extended, as a parameter number. It is an error when the offset is not below par_count.
- R7: The store returns the byte-count field of the entry's tag (0 to 15). The entry holds ceil(count/4) words. A count of 0, or an offset not below the word count, is an error, so an entry of one word accepts only offset 0.
- R8: On an invalid descriptor the block raises err, issues no write for it or for any later descriptor, and still pulses done.
- R9: A count above 64 raises err and pulses done without any descriptor read or write.
- R10: While a write waits for wr_ready, wr_addr and wr_data hold steady, and no descriptor is fetched until the write is accepted.
- R11: done is high for exactly one cycle per run, after the last accepted write. A count of 0 gives done with no writes. err stays as the run left it until the next start.
- R12: A start pulse that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| num_writes | input | 8 | Number of descriptors in the map |
| par_count | input | 8 | Number of caller parameters present |
| const_count | input | 8 | Number of constants in the pool |
| desc_rd_en | output | 1 | Descriptor memory read strobe |
| desc_rd_addr | output | 6 | Descriptor number to read |
| desc_rd_data | input | 64 | Descriptor, valid one cycle after the strobe |
| val_rd_en | output | 1 | Parameter/constant store read strobe |
| val_rd_const | output | 1 | High selects the constant pool |
| val_rd_idx | output | 8 | Entry number in the selected store |
| val_rd_word | output | 2 | 32-bit word within the entry |
| val_rd_len | input | 4 | Byte-count field of the entry tag, one cycle after the strobe |
| val_rd_data | input | 32 | Selected word, one cycle after the strobe |
| wr_valid | output | 1 | Register write request |
| wr_addr | output | 32 | Register write address |
| wr_data | output | 32 | Register write data |
| wr_ready | input | 1 | Target accepts the write |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Run stopped on an invalid map |

## Verification
The hardest case to reach from the ports is an error in the middle of a long list that arrives while writes are being stalled. The block must then stop cleanly after a partly completed sequence. The stimulus builds random maps with a fixed seed. A small share of descriptors are made invalid on purpose: an unknown entry, an offset past the end of an entry, a zero-length tag, or a reference by name that is out of range. Random wr_ready backpressure runs alongside. Directed runs add the counts 0, 64 and 65, and a start pulse repeated in the middle of a full-length run.

// File: rtl/cml_pkg.sv
package cml_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int IDX_W      = 16;
  localparam int OFF_W      = 16;
  localparam int CONST_BASE = 64;
  localparam logic [IDX_W-1:0] IDX_SCALAR = 16'hFFFE;
  localparam logic [IDX_W-1:0] IDX_BYNAME = 16'hFFFF;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [IDX_W-1:0]  idx;
    logic [OFF_W-1:0]  off;
  } desc_t;

  typedef enum logic [1:0] {K_PARAM, K_CONST, K_SCALAR, K_BYNAME} kind_e;

  // number of 32-bit words held by an entry with the given byte count
  function automatic logic [2:0] len_to_words(input logic [3:0] len);
    logic [4:0] sum;
    sum = {1'b0, len} + 5'd3;
    return sum[4:2];
  endfunction

  // constant number for a pool index (index minus the pool base)
  function automatic logic [IDX_W-1:0] const_number(input logic [IDX_W-1:0] idx);
    return idx - IDX_W'(CONST_BASE);
  endfunction
endpackage

// File: rtl/cml_index_decode.sv
module cml_index_decode
  import cml_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 8
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  off,
  input  logic [CNT_W-1:0]  par_count,
  input  logic [CNT_W-1:0]  const_count,
  output kind_e             kind,
  output logic [SEL_W-1:0]  sel,
  output logic              exists,
  output logic [DATA_W-1:0] imm
);
  logic [IDX_W-1:0] cnum;
  assign cnum = const_number(idx);

  always_comb begin
    kind   = K_PARAM;
    sel    = '0;
    exists = 1'b0;
    imm    = '0;
    if (idx == IDX_SCALAR) begin
      kind   = K_SCALAR;
      exists = 1'b1;
      imm    = DATA_W'(off);
    end else if (idx == IDX_BYNAME) begin
      kind   = K_BYNAME;
      exists = (off < OFF_W'(par_count));
      imm    = DATA_W'(off);
    end else if (idx < IDX_W'(CONST_BASE)) begin
      kind   = K_PARAM;
      exists = (idx < IDX_W'(par_count));
      sel    = idx[SEL_W-1:0];
    end else begin
      kind   = K_CONST;
      exists = (cnum < IDX_W'(const_count));
      sel    = cnum[SEL_W-1:0];
    end
  end

  // R5: the scalar form is always valid
  always_comb scalar_valid_chk: assert (!(idx == IDX_SCALAR) || exists);
endmodule

// File: rtl/cml_value_check.sv
module cml_value_check
  import cml_pkg::*;
(
  input  logic [3:0]        len,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] rdata,
  output logic              ok,
  output logic [DATA_W-1:0] data
);
  logic [2:0] words;
  assign words = len_to_words(len);
  assign ok    = (words != 3'd0) && (off < OFF_W'(words));
  assign data  = rdata;

  // R7: a single-word entry never accepts a nonzero offset
  always_comb single_word_chk: assert (!(words == 3'd1 && off != '0) || !ok);
endmodule

// File: rtl/cml_bus_port.sv
module cml_bus_port
  import cml_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              accepted
);
  assign accepted = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_addr  <= ld_addr;
      wr_data  <= ld_data;
    end else if (accepted) begin
      wr_valid <= 1'b0;
    end
  end

  // R10
  property p_hold;
    @(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data));
  endproperty
  hold_while_stalled_chk: assert property (p_hold);

  // R10: a new write is never loaded over a pending one
  property p_no_overwrite;
    @(posedge clk) disable iff (!rst_n) load |-> !wr_valid;
  endproperty
  no_overwrite_chk: assert property (p_no_overwrite);
endmodule

// File: rtl/cml_loader.sv
module cml_loader
  import cml_pkg::*;
#(
  parameter int MAX_WRITES = 64,
  parameter int CNT_W      = 8,
  parameter int SEL_W      = 8,
  parameter int WORD_W     = 2,
  localparam int DA_W      = $clog2(MAX_WRITES),
  localparam int CUR_W     = DA_W + 1,
  localparam int DESC_W    = ADDR_W + IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  num_writes,
  input  logic [CNT_W-1:0]  par_count,
  input  logic [CNT_W-1:0]  const_count,
  output logic              desc_rd_en,
  output logic [DA_W-1:0]   desc_rd_addr,
  input  logic [DESC_W-1:0] desc_rd_data,
  output logic              val_rd_en,
  output logic              val_rd_const,
  output logic [SEL_W-1:0]  val_rd_idx,
  output logic [WORD_W-1:0] val_rd_word,
  input  logic [3:0]        val_rd_len,
  input  logic [DATA_W-1:0] val_rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ready,
  output logic              done,
  output logic              err
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DESC, S_DECODE, S_VALUE, S_ISSUE, S_DONE} state_e;

  state_e           state;
  logic [CUR_W-1:0] cur;
  logic [CNT_W-1:0] count_q;
  desc_t            desc_q;
  logic             err_q;

  // named internal events
  logic             start_ok;
  logic             count_bad;
  logic             last_desc;
  logic             bus_load;
  logic             bus_accepted;
  logic [DATA_W-1:0] load_data;
  kind_e            dec_kind;
  logic [SEL_W-1:0] dec_sel;
  logic             dec_exists;
  logic [DATA_W-1:0] dec_imm;
  logic             val_ok;
  logic [DATA_W-1:0] val_data;
  logic             dec_needs_store;

  assign start_ok  = (state == S_IDLE) && start;
  assign count_bad = (num_writes > CNT_W'(MAX_WRITES));
  assign last_desc = (CNT_W'(cur) + CNT_W'(1)) == count_q;

  cml_index_decode #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_dec (
    .idx(desc_q.idx), .off(desc_q.off),
    .par_count(par_count), .const_count(const_count),
    .kind(dec_kind), .sel(dec_sel), .exists(dec_exists), .imm(dec_imm)
  );

  cml_value_check u_val (
    .len(val_rd_len), .off(desc_q.off), .rdata(val_rd_data),
    .ok(val_ok), .data(val_data)
  );

  assign dec_needs_store = (dec_kind == K_PARAM) || (dec_kind == K_CONST);

  // read strobes
  assign desc_rd_en   = (state == S_FETCH);
  assign desc_rd_addr = cur[DA_W-1:0];
  assign val_rd_en    = (state == S_DECODE) && dec_exists && dec_needs_store;
  assign val_rd_const = (dec_kind == K_CONST);
  assign val_rd_idx   = dec_sel;
  assign val_rd_word  = desc_q.off[WORD_W-1:0];

  // bus load request
  always_comb begin
    bus_load  = 1'b0;
    load_data = dec_imm;
    if (state == S_DECODE && dec_exists && !dec_needs_store) begin
      bus_load = 1'b1;
    end else if (state == S_VALUE && val_ok) begin
      bus_load  = 1'b1;
      load_data = val_data;
    end
  end

  cml_bus_port u_bus (
    .clk(clk), .rst_n(rst_n), .load(bus_load),
    .ld_addr(desc_q.addr), .ld_data(load_data),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .accepted(bus_accepted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur     <= '0;
      count_q <= '0;
      desc_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          count_q <= num_writes;
          cur     <= '0;
          err_q   <= count_bad;
          if (count_bad || num_writes == '0) state <= S_DONE;
          else                               state <= S_FETCH;
        end
        S_FETCH:  state <= S_DESC;
        S_DESC: begin
          desc_q <= desc_t'(desc_rd_data);
          state  <= S_DECODE;
        end
        S_DECODE: begin
          if (!dec_exists) begin
            err_q <= 1'b1;
            state <= S_DONE;
          end else if (dec_needs_store) state <= S_VALUE;
          else                          state <= S_ISSUE;
        end
        S_VALUE: begin
          if (val_ok) state <= S_ISSUE;
          else begin
            err_q <= 1'b1;
            state <= S_DONE;
          end
        end
        S_ISSUE: if (bus_accepted) begin
          if (last_desc) state <= S_DONE;
          else begin
            cur   <= cur + CUR_W'(1);
            state <= S_FETCH;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done = (state == S_DONE);
  assign err  = err_q;

  // R10: no descriptor fetch while a write is outstanding
  property p_fetch_idle_bus;
    @(posedge clk) disable iff (!rst_n) desc_rd_en |-> !wr_valid;
  endproperty
  no_fetch_during_write_chk: assert property (p_fetch_idle_bus);

  // R11
  property p_done_pulse;
    @(posedge clk) disable iff (!rst_n) done |=> !done;
  endproperty
  done_single_cycle_chk: assert property (p_done_pulse);

  // R8
  property p_err_quiet;
    @(posedge clk) disable iff (!rst_n) (err && state != S_IDLE) |-> (!wr_valid && !bus_load);
  endproperty
  no_write_after_err_chk: assert property (p_err_quiet);

  // R2
  property p_fetch_range;
    @(posedge clk) disable iff (!rst_n) desc_rd_en |-> (CNT_W'(desc_rd_addr) < count_q);
  endproperty
  fetch_in_range_chk: assert property (p_fetch_range);

  // R9
  property p_bad_count;
    @(posedge clk) disable iff (!rst_n) (start_ok && count_bad) |=> (done && err);
  endproperty
  bad_count_chk: assert property (p_bad_count);

  // R12
  property p_busy_start;
    @(posedge clk) disable iff (!rst_n)
      (start && state != S_IDLE && state != S_DONE) |=> $stable(count_q);
  endproperty
  busy_start_ignored_chk: assert property (p_busy_start);
endmodule

// File: tb/tb_cml_loader.sv
`timescale 1ns/1ps
module tb_cml_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  num_writes = '0, par_count = '0, const_count = '0;
  logic        desc_rd_en;
  logic [5:0]  desc_rd_addr;
  logic [63:0] desc_rd_data;
  logic        val_rd_en, val_rd_const;
  logic [7:0]  val_rd_idx;
  logic [1:0]  val_rd_word;
  logic [3:0]  val_rd_len;
  logic [31:0] val_rd_data;
  logic        wr_valid, wr_ready, done, err;
  logic [31:0] wr_addr, wr_data;

  always #4 clk = ~clk;

  cml_loader dut (.*);

  // memories modelled in the bench
  logic [63:0] dmem [64];
  logic [3:0]  plen [64];
  logic [31:0] pdat [64][4];
  logic [3:0]  clen [64];
  logic [31:0] cdat [64][4];

  always_ff @(posedge clk) begin
    if (desc_rd_en) desc_rd_data <= dmem[desc_rd_addr];
    if (val_rd_en) begin
      if (val_rd_const) begin
        val_rd_len  <= clen[val_rd_idx[5:0]];
        val_rd_data <= cdat[val_rd_idx[5:0]][val_rd_word];
      end else begin
        val_rd_len  <= plen[val_rd_idx[5:0]];
        val_rd_data <= pdat[val_rd_idx[5:0]][val_rd_word];
      end
    end
  end

  int checks = 0, fails = 0;
  bit bp_on = 1'b0;

  initial wr_ready = 1'b1;
  always @(posedge clk) begin
    #1 wr_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor, sampled at the falling edge
  logic [31:0] got_addr [70];
  logic [31:0] got_data [70];
  int nw = 0, done_cnt = 0, dbl = 0, viol = 0;
  logic prev_stall = 0, prev_done = 0;
  logic [31:0] prev_a, prev_d;
  always @(negedge clk) begin
    if (prev_stall && !(wr_valid && wr_addr == prev_a && wr_data == prev_d)) viol++;
    if (desc_rd_en && wr_valid) viol++;
    if (wr_valid && wr_ready) begin
      if (nw < 70) begin got_addr[nw] = wr_addr; got_data[nw] = wr_data; end
      nw++;
    end
    prev_stall = wr_valid && !wr_ready;
    prev_a = wr_addr; prev_d = wr_data;
    if (done) begin done_cnt++; if (prev_done) dbl++; end
    prev_done = done;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected results
  logic [31:0] exp_addr [70];
  logic [31:0] exp_data [70];
  string       exp_req  [70];
  int          exp_n;
  bit          exp_err;

  function automatic int n_words(input logic [3:0] l);
    int w = l / 4;
    if (l % 4 != 0) w++;
    return w;
  endfunction

  function automatic void predict(input int n);
    exp_n = 0; exp_err = 0;
    if (n > 64) begin exp_err = 1; return; end
    for (int i = 0; i < n; i++) begin
      logic [15:0] ix, of;
      bit ok; logic [31:0] v; string rq;
      ix = dmem[i][31:16]; of = dmem[i][15:0]; ok = 0; v = 0;
      if (ix == 16'hFFFE) begin ok = 1; v = {16'h0, of}; rq = "R5"; end
      else if (ix == 16'hFFFF) begin ok = (of < par_count); v = {16'h0, of}; rq = "R6"; end
      else if (ix < 64) begin
        rq = "R3";
        if (ix < par_count && of < n_words(plen[ix])) begin ok = 1; v = pdat[ix][of[1:0]]; end
      end else begin
        int c = ix - 64;
        rq = "R4";
        if (c < const_count && of < n_words(clen[c])) begin ok = 1; v = cdat[c][of[1:0]]; end
      end
      if (!ok) begin exp_err = 1; return; end
      exp_addr[exp_n] = dmem[i][63:32]; exp_data[exp_n] = v; exp_req[exp_n] = rq;
      exp_n++;
    end
  endfunction

  task automatic run(input int n, input bit restart);
    int t;
    predict(n);
    nw = 0; done_cnt = 0; dbl = 0; viol = 0;
    @(negedge clk) num_writes = 8'(n); start = 1;
    @(negedge clk) start = 0;
    if (restart) begin
      repeat (6) @(negedge clk);
      num_writes = 8'd3; start = 1;            // R12: mid-run start
      @(negedge clk) start = 0;
    end
    t = 0;
    while (done_cnt == 0 && t < 4000) begin @(negedge clk); #1; t++; end
    if (t >= 4000) begin checks++; fails++; $display("FAIL R11 watchdog actual=timeout expected=done"); end
    repeat (3) @(negedge clk);
    #1;
    check("R8/R9 err", 32'(err), 32'(exp_err));
    check("R2 write count", nw, exp_n);
    for (int i = 0; i < exp_n && i < nw; i++) begin
      check({exp_req[i], " addr"}, got_addr[i], exp_addr[i]);
      check({exp_req[i], " data"}, got_data[i], exp_data[i]);
    end
    check("R11 done pulses", done_cnt, 1);
    check("R11 done width", dbl, 0);
    check("R10 handshake", viol, 0);
  endtask

  function automatic logic [63:0] mk(input logic [31:0] a, input logic [15:0] ix, input logic [15:0] of);
    return {a, ix, of};
  endfunction

  // random valid entry contents
  function automatic void fill_stores();
    for (int i = 0; i < 64; i++) begin
      plen[i] = 4'(1 + $urandom % 15);
      clen[i] = 4'(1 + $urandom % 15);
      for (int w = 0; w < 4; w++) begin pdat[i][w] = $urandom; cdat[i][w] = $urandom; end
    end
  endfunction

  function automatic logic [63:0] rand_desc();
    int r = $urandom % 41;
    logic [31:0] a = $urandom;
    if (r < 16) begin
      int p = $urandom % par_count;
      return mk(a, 16'(p), 16'($urandom % n_words(plen[p])));
    end else if (r < 28 && const_count > 0) begin
      int c = $urandom % const_count;
      return mk(a, 16'(64 + c), 16'($urandom % n_words(clen[c])));
    end else if (r < 34) return mk(a, 16'hFFFE, 16'($urandom));
    else if (r < 40) return mk(a, 16'hFFFF, 16'($urandom % par_count));
    else return mk(a, 16'($urandom), 16'($urandom % 6));
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    fill_stores();
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", 32'(done), 0);
    check("R1 err", 32'(err), 0);
    check("R1 wr_valid", 32'(wr_valid), 0);
    check("R1 desc_rd_en", 32'(desc_rd_en), 0);
    check("R1 val_rd_en", 32'(val_rd_en), 0);
    rst_n = 1;
    par_count = 8'd10; const_count = 8'd8;
    plen[0] = 4'd4; plen[1] = 4'd9; plen[2] = 4'd0; clen[3] = 4'd13;

    // R11: empty map
    run(0, 0);
    // R9: too many writes
    run(65, 0);
    // R3/R4/R5/R6/R7 directed valid list
    dmem[0] = mk(32'h100, 16'd1, 16'd2);      // third word of a 9-byte parameter
    dmem[1] = mk(32'h104, 16'd67, 16'd3);     // constant 3, fourth word
    dmem[2] = mk(32'h108, 16'hFFFE, 16'hBEEF);
    dmem[3] = mk(32'h10C, 16'hFFFF, 16'd9);
    dmem[4] = mk(32'h110, 16'd0, 16'd0);
    run(5, 0);
    // R7: offset past a single-word parameter
    dmem[2] = mk(32'h108, 16'd0, 16'd1);
    run(5, 0);
    // R7: zero-length tag
    dmem[2] = mk(32'h108, 16'd2, 16'd0);
    run(5, 0);
    // R6: name reference out of range
    dmem[2] = mk(32'h108, 16'hFFFF, 16'd10);
    run(5, 0);
    // R8: missing parameter and missing constant
    dmem[2] = mk(32'h108, 16'd10, 16'd0);
    run(5, 0);
    dmem[2] = mk(32'h108, 16'd72, 16'd0);
    run(5, 0);
    // R11: err persists after the run, cleared by next start
    check("R11 err held", 32'(err), 1);
    dmem[2] = mk(32'h108, 16'hFFFE, 16'd1);
    run(5, 0);

    // R2/R10/R12: full 64-entry map with backpressure and a repeated start
    plen[2] = 4'd5;
    bp_on = 1;
    for (int i = 0; i < 64; i++) begin
      int p = $urandom % 10;
      dmem[i] = mk(32'(i * 4), 16'(p), 16'($urandom % n_words(plen[p])));
    end
    run(64, 1);

    // random runs
    for (int k = 0; k < 40; k++) begin
      fill_stores();
      par_count   = 8'(1 + $urandom % 64);
      const_count = 8'($urandom % 33);
      if (k % 7 == 0) plen[$urandom % 64] = 4'd0;
      for (int i = 0; i < 64; i++) dmem[i] = rand_desc();
      bp_on = (k % 2 == 0);
      run($urandom % 65, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule